// File: doc/BRIEF.md
# Dual-Timer Clock Prescaler with Held Release

This block produces count-enable ticks for two synchronous timer/counters. Each timer picks its own tick source with a 3-bit select: no ticks, every system clock, one of four divided rates from a shared 10-bit free-running prescaler, or the rising or falling edges of an external pin. The external pin goes through a two-flop synchronizer and an edge detector clocked by the system clock. External edges bypass the prescaler and are never divided.

A byte-wide control register holds a hold-mode flag and two prescaler reset bits. With hold mode off, writing the synchronous reset bit clears the shared prescaler for one cycle, and the bit then clears itself. With hold mode on, the reset bits keep whatever value was written. Both timers then stay halted with the prescaler at zero, so software can load them safely. Writing the register with hold mode off and the reset bits at zero releases both timers on the same clock edge. The second reset bit serves a timer domain outside this block and is only exported as a level.

Top module: `tmr_clk_gen`

## Requirements
- R1: After reset the register reads 0x00 and the async-reset level output is 0. Bit 7 is the hold-mode flag, bit 1 is the async prescaler reset and bit 0 is the sync prescaler reset. Bits 6:2 always read 0, whatever is written.
- R2: With hold mode 0, a write sets bits 1:0 to the written values for exactly one cycle, and both bits read 0 on the following cycle. A sync reset bit of 1 forces the prescaler count to 0.
- R3: With hold mode 1 and no write, the register value does not change. While the sync reset bit is 1, selects 1 to 5 give no ticks and the prescaler holds at zero.
- R4: Writing 0x00 from a held state releases both timers together. Counting j from 0 in the first cycle after the write edge, select 1 ticks in every cycle and a divide-by-N select ticks when j mod N equals N-1.
- R5: Select encoding: 0 gives no ticks, 1 gives every cycle, 2/3/4/5 give divide by 8/64/256/1024, 6 gives the external falling edge and 7 gives the external rising edge. Select 0 never ticks, even while the pin toggles.
- R6: After a one-cycle sync reset pulse, a divide-by-N select ticks in exactly the cycles where the cycle index j satisfies j mod N equal to N-1. The index j is 0 in the cycle after the pulse cycle.
- R7: Each external edge of the selected polarity gives exactly one tick, one cycle wide. The tick appears in the system-clock cycle that begins at the second rising clock edge after the pin change.
- R8: External-edge ticks keep coming while the prescaler is held in reset, and each edge gives one tick with no division.
- R9: The async-reset level output follows register bit 1, including the one-cycle pulse in hold mode 0 and the held value in hold mode 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr_en | input | 1 | Control register write strobe |
| reg_wdata | input | 8 | Control register write data |
| reg_rdata | output | 8 | Control register read value |
| ext_pin | input | 1 | External clock pin, asynchronous |
| sel_a | input | 3 | Tick source select for timer A |
| sel_b | input | 3 | Tick source select for timer B |
| tick_a | output | 1 | Count enable for timer A |
| tick_b | output | 1 | Count enable for timer B |
| async_hold | output | 1 | Exported async prescaler reset level |

## Verification
Some rules are checked on every cycle: reserved bits reading zero, the self-clearing reset bits in hold mode 0, the frozen register in hold mode 1, silence while the prescaler is held or the select is 0, and rising-edge ticks matching the pin two and three cycles back. Only the bench scenarios can show the exact tick phase of every divided rate after a clear or a release. The same goes for both timers starting on one edge, and for external edges still passing while the prescaler is held.

// File: rtl/tcg_pkg.sv
// Shared constants and types for the dual-timer clock prescaler.
// Assumes the divided rates are powers of two taken from one counter.
package tcg_pkg;
    // Tick source select encoding.
    typedef enum logic [2:0] {
        CS_OFF      = 3'd0,
        CS_SYS      = 3'd1,
        CS_DIV8     = 3'd2,
        CS_DIV64    = 3'd3,
        CS_DIV256   = 3'd4,
        CS_DIV1024  = 3'd5,
        CS_EXT_FALL = 3'd6,
        CS_EXT_RISE = 3'd7
    } clk_sel_e;

    localparam int NUM_TAPS = 4;
    // log2 of each divided rate, in select order 2..5
    localparam int TAP_EXP [NUM_TAPS] = '{3, 6, 8, 10};
    localparam int MAX_EXP = 10;
endpackage

// File: rtl/tcg_ctrl_reg.sv
// Control register: hold-mode flag (bit 7), async reset (bit 1) and
// sync reset (bit 0). In hold mode 0 the reset bits last one cycle.
// Assumes writes are single-cycle strobes in the clk domain.
module tcg_ctrl_reg (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  logic [7:0] wdata,
    output logic [7:0] rdata,
    output logic       sync_clr,
    output logic       async_clr
);
    logic hold_mode;
    logic unused_wbits;

    assign unused_wbits = ^wdata[6:2];

    // Register update: write loads, otherwise self-clear unless holding.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_mode <= 1'b0;
            async_clr <= 1'b0;
            sync_clr  <= 1'b0;
        end else if (wr_en) begin
            hold_mode <= wdata[7];
            async_clr <= wdata[1];
            sync_clr  <= wdata[0];
        end else if (!hold_mode) begin
            async_clr <= 1'b0;
            sync_clr  <= 1'b0;
        end
    end

    // Read view with reserved bits forced to zero.
    always_comb begin
        rdata = {hold_mode, 5'b00000, async_clr, sync_clr};
    end
endmodule

// File: rtl/tcg_prescaler.sv
// Shared free-running prescaler producing one-cycle taps at each
// divided rate. Assumes PRE_W covers the largest tap exponent.
module tcg_prescaler #(
    parameter int PRE_W = tcg_pkg::MAX_EXP
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         clr,
    output logic                         sys_tick,
    output logic [tcg_pkg::NUM_TAPS-1:0] tap_tick
);
    logic [PRE_W-1:0] cnt;

    // Counter: held at zero while cleared, free-running otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    // Undivided rate, silenced during clear.
    always_comb begin
        sys_tick = !clr;
    end

    // One tap per divided rate, pulsing when its low bits are all ones.
    for (genvar i = 0; i < tcg_pkg::NUM_TAPS; i++) begin : g_tap
        localparam int E = tcg_pkg::TAP_EXP[i];
        assign tap_tick[i] = !clr && (&cnt[E-1:0]);
    end
endmodule

// File: rtl/tcg_edge_det.sv
// Synchronizes the external pin and flags its rising and falling
// edges. Assumes each pin level lasts longer than one clk cycle.
module tcg_edge_det #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin,
    output logic rise,
    output logic fall
);
    logic [SYNC_STAGES:0] sh;

    // Synchronizer chain plus one delayed copy for comparison.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh <= '0;
        end else begin
            sh <= {sh[SYNC_STAGES-1:0], pin};
        end
    end

    // Edge flags from synchronized level against its delayed copy.
    always_comb begin
        rise = sh[SYNC_STAGES-1] && !sh[SYNC_STAGES];
        fall = !sh[SYNC_STAGES-1] && sh[SYNC_STAGES];
    end
endmodule

// File: rtl/tcg_tick_sel.sv
// Per-timer tick source multiplexer driven by a 3-bit select.
// Assumes all inputs are single-cycle pulses in the clk domain.
module tcg_tick_sel (
    input  logic                         sys_tick,
    input  logic [tcg_pkg::NUM_TAPS-1:0] tap_tick,
    input  logic                         ext_rise,
    input  logic                         ext_fall,
    input  logic [2:0]                   sel,
    output logic                         tick
);
    import tcg_pkg::*;

    // Decode the select into one tick source.
    always_comb begin
        case (clk_sel_e'(sel))
            CS_OFF:      tick = 1'b0;
            CS_SYS:      tick = sys_tick;
            CS_DIV8:     tick = tap_tick[0];
            CS_DIV64:    tick = tap_tick[1];
            CS_DIV256:   tick = tap_tick[2];
            CS_DIV1024:  tick = tap_tick[3];
            CS_EXT_FALL: tick = ext_fall;
            CS_EXT_RISE: tick = ext_rise;
            default:     tick = 1'b0;
        endcase
    end
endmodule

// File: rtl/tmr_clk_gen.sv
// Top: control register, shared prescaler, pin edge detector and one
// tick selector per timer. Assumes ext_pin stays below clk/2.5.
module tmr_clk_gen #(
    parameter int PRE_W       = tcg_pkg::MAX_EXP,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       reg_wr_en,
    input  logic [7:0] reg_wdata,
    output logic [7:0] reg_rdata,
    input  logic       ext_pin,
    input  logic [2:0] sel_a,
    input  logic [2:0] sel_b,
    output logic       tick_a,
    output logic       tick_b,
    output logic       async_hold
);
    localparam int NUM_TIMERS = 2;

    logic                         sync_clr;
    logic                         sys_tick;
    logic [tcg_pkg::NUM_TAPS-1:0] tap_tick;
    logic                         ext_rise;
    logic                         ext_fall;
    logic [2:0]                   sel_arr  [NUM_TIMERS];
    logic [NUM_TIMERS-1:0]        tick_arr;

    tcg_ctrl_reg u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (reg_wr_en),
        .wdata     (reg_wdata),
        .rdata     (reg_rdata),
        .sync_clr  (sync_clr),
        .async_clr (async_hold)
    );

    tcg_prescaler #(.PRE_W(PRE_W)) u_pre (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (sync_clr),
        .sys_tick (sys_tick),
        .tap_tick (tap_tick)
    );

    tcg_edge_det #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
        .clk   (clk),
        .rst_n (rst_n),
        .pin   (ext_pin),
        .rise  (ext_rise),
        .fall  (ext_fall)
    );

    assign sel_arr[0] = sel_a;
    assign sel_arr[1] = sel_b;

    for (genvar t = 0; t < NUM_TIMERS; t++) begin : g_timer
        tcg_tick_sel u_sel (
            .sys_tick (sys_tick),
            .tap_tick (tap_tick),
            .ext_rise (ext_rise),
            .ext_fall (ext_fall),
            .sel      (sel_arr[t]),
            .tick     (tick_arr[t])
        );
    end

    assign tick_a = tick_arr[0];
    assign tick_b = tick_arr[1];
endmodule

// File: rtl/tcg_chk.sv
// Checker for tmr_clk_gen port behaviour, bound to the top module.
module tcg_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       reg_wr_en,
    input logic [7:0] reg_wdata,
    input logic [7:0] reg_rdata,
    input logic       ext_pin,
    input logic [2:0] sel_a,
    input logic [2:0] sel_b,
    input logic       tick_a,
    input logic       tick_b,
    input logic       async_hold
);
    logic [1:0] warm;
    logic       unused_wd;

    assign unused_wd = ^{reg_wdata[6:2], reg_wdata[0]};

    // Counts cycles since reset so pin history checks wait for it.
    always_ff @(posedge clk) begin
        if (!rst_n) warm <= 2'd0;
        else if (warm != 2'd3) warm <= warm + 2'd1;
    end

    // R1
    reserved_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rdata[6:2] == 5'd0);

    // R2
    self_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!reg_wr_en && !reg_rdata[7]) |=> (reg_rdata[1:0] == 2'b00));

    // R3
    hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!reg_wr_en && reg_rdata[7]) |=> $stable(reg_rdata));

    // R3
    held_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rdata[0] && sel_a >= 3'd1 && sel_a <= 3'd5) |-> !tick_a);

    // R5
    off_quiet_a_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_a == 3'd0) |-> !tick_a);

    // R5
    off_quiet_b_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_b == 3'd0) |-> !tick_b);

    // R7
    rise_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (warm == 2'd3 && sel_a == 3'd7) |->
            (tick_a == ($past(ext_pin, 2) && !$past(ext_pin, 3))));

    // R9
    async_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr_en |=> (async_hold == $past(reg_wdata[1])));
endmodule

bind tmr_clk_gen tcg_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .reg_wr_en  (reg_wr_en),
    .reg_wdata  (reg_wdata),
    .reg_rdata  (reg_rdata),
    .ext_pin    (ext_pin),
    .sel_a      (sel_a),
    .sel_b      (sel_b),
    .tick_a     (tick_a),
    .tick_b     (tick_b),
    .async_hold (async_hold)
);

// File: tb/tmr_clk_gen_bench.sv
module tmr_clk_gen_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr = 1'b0;
    logic [7:0] wd = 8'h00;
    logic       pin = 1'b0;
    logic [2:0] sa = 3'd0;
    logic [2:0] sb = 3'd0;
    wire  [7:0] rd;
    wire        ta;
    wire        tb;
    wire        ah;

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    tmr_clk_gen u_tmr_clk_gen (
        .clk        (clk),
        .rst_n      (rst_n),
        .reg_wr_en  (wr),
        .reg_wdata  (wd),
        .reg_rdata  (rd),
        .ext_pin    (pin),
        .sel_a      (sa),
        .sel_b      (sb),
        .tick_a     (ta),
        .tick_b     (tb),
        .async_hold (ah)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Write starts at a falling edge and ends just after the write edge.
    task automatic wr_reg(input logic [7:0] v);
        @(negedge clk);
        wr = 1'b1;
        wd = v;
        @(posedge clk);
        #1;
        wr = 1'b0;
    endtask

    function automatic int div_of(input logic [2:0] s);
        case (s)
            3'd1: return 1;
            3'd2: return 8;
            3'd3: return 64;
            3'd4: return 256;
            default: return 1024;
        endcase
    endfunction

    // Sync reset pulse, then the exact tick phase of both timers.
    task automatic run_div(input logic [2:0] s_a, input logic [2:0] s_b);
        int na;
        int nb;
        na = div_of(s_a);
        nb = div_of(s_b);
        sa = s_a;
        sb = s_b;
        wr_reg(8'h01);
        @(negedge clk);
        chk("R2 pulse visible", rd, 8'h01);
        chk("R3 no tick a during clear", ta, 0);
        chk("R3 no tick b during clear", tb, 0);
        for (int j = 0; j < 2048; j++) begin
            @(negedge clk);
            if (j == 0) chk("R2 self-clear", rd, 8'h00);
            chk("R6 tick a phase", ta, ((j % na) == na - 1) ? 1 : 0);
            chk("R6 tick b phase", tb, ((j % nb) == nb - 1) ? 1 : 0);
        end
    endtask

    initial begin
        bit h1;
        bit h2;
        bit h3;
        int c;
        repeat (5) @(negedge clk);
        chk("R1 reset read", rd, 8'h00);
        chk("R1 reset async level", ah, 0);
        chk("R5 off during reset", ta, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 read after reset", rd, 8'h00);

        // R6 sweep of every rate pair
        for (int a = 1; a <= 5; a++) begin
            for (int b = 1; b <= 5; b++) begin
                run_div(3'(a), 3'(b));
            end
        end

        // R3 hold, R1 reserved bits, R9 export, R4 joint release
        sa = 3'd1;
        sb = 3'd2;
        wr_reg(8'h81);
        for (int k = 0; k < 40; k++) begin
            @(negedge clk);
            chk("R3 held read", rd, 8'h81);
            chk("R3 held tick a", ta, 0);
            chk("R3 held tick b", tb, 0);
        end
        wr_reg(8'hFF);
        @(negedge clk);
        chk("R1 reserved read zero", rd, 8'h83);
        chk("R9 async level held", ah, 1);
        repeat (3) @(negedge clk);
        chk("R3 write still held", rd, 8'h83);
        sb = 3'd3;
        wr_reg(8'h00);
        for (int j = 0; j < 256; j++) begin
            @(negedge clk);
            if (j == 0) begin
                chk("R4 released read", rd, 8'h00);
                chk("R9 async level released", ah, 0);
            end
            chk("R4 release sys tick", ta, 1);
            chk("R4 release div64 phase", tb, ((j % 64) == 63) ? 1 : 0);
        end

        // R9 one-cycle async pulse in hold mode 0
        wr_reg(8'h02);
        @(negedge clk);
        chk("R9 async pulse", ah, 1);
        @(negedge clk);
        chk("R9 async pulse cleared", ah, 0);

        // R7 and R8: external edges while the prescaler is held
        sa = 3'd7;
        sb = 3'd6;
        wr_reg(8'h81);
        h1 = 1'b0;
        h2 = 1'b0;
        h3 = 1'b0;
        c = 0;
        for (int hp = 2; hp <= 5; hp++) begin
            for (int k = 0; k < hp * 20; k++) begin
                @(negedge clk);
                chk("R7 R8 rise tick", ta, (h2 && !h3) ? 1 : 0);
                chk("R7 R8 fall tick", tb, (!h2 && h3) ? 1 : 0);
                if ((c % hp) == hp - 1) pin = ~pin;
                h3 = h2;
                h2 = h1;
                h1 = pin;
                c++;
            end
        end

        // R5 select 0 ignores a toggling pin
        sa = 3'd0;
        sb = 3'd0;
        for (int k = 0; k < 40; k++) begin
            @(negedge clk);
            chk("R5 off tick a", ta, 0);
            chk("R5 off tick b", tb, 0);
            if ((k % 3) == 2) pin = ~pin;
        end
        wr_reg(8'h00);
        @(negedge clk);
        chk("R4 final release read", rd, 8'h00);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule